// File: doc/BRIEF.md
# Clock-Qualified Memory Map Decoder

This block turns the top three bits of a 16-bit processor address, together with the processor's phase-2 clock, into the select and enable strobes for three devices: a 32K ROM that fills the upper half of the map, a RAM in the bottom quarter, and a peripheral adapter in the 8K window just under the ROM. The ROM sits at the top so that the processor's reset vector is fetched from it at power-up. The RAM chip select is qualified by the phase-2 clock. As a result, the RAM can only be written while phase 2 is high, when the address and data lines have settled.

The map is only partly decoded. The band from 0x4000 to 0x5FFF selects no device. The peripheral answers anywhere in its 8K window. The block also reports a one-hot region code that says which of the four bands the address falls in.

Small behavioural memories and a read-data multiplexer surround the decoder so that whole bus cycles can be exercised. The RAM model holds 2^RAM_AW bytes and repeats through the RAM band. The ROM model computes its contents from the address. The peripheral's read data comes in on a port.

Top module: `mm_sys_decode`

## Requirements
- R1: `rom_cs_n` is 0 exactly when addr[15] is 1 (0x8000–0xFFFF), whatever the level of `phi2`.
- R2: `ram_cs_n` is 0 exactly when addr[15] is 0 and `phi2` is 1.
- R3: `ram_oe_n` is 0 exactly when addr[14] is 0. The RAM is therefore enabled for data only in 0x0000–0x3FFF.
- R4: `per_cs1` follows addr[13`, and `per_cs2_n` is 0 exactly when addr[15]=0 and addr[14]=1. Both selects are active together only in 0x6000–0x7FFF.
- R5: `region` is one-hot, with exactly one bit set at any time: bit0 for RAM (0x0000–0x3FFF), bit1 for the unused band (0x4000–0x5FFF), bit2 for the peripheral (0x6000–0x7FFF) and bit3 for ROM (0x8000–0xFFFF).
- R6: `rdata` depends on the band. For ROM it returns the ROM byte. For the peripheral it returns `per_rdata`. For RAM it returns the stored byte while both RAM strobes are active. For the unused band, or for RAM while `phi2` is 0, it returns 0xFF.
- R7: The ROM byte at address A is A[7:0] XOR A[15:8]. The exceptions are 0xFFFC, which holds RESET_VEC[7:0] (default 0x00), and 0xFFFD, which holds RESET_VEC[15:8] (default 0x80).
- R8: A RAM write happens on a rising `clk` edge when `cpu_we`=1, `phi2`=1 and the address is in 0x0000–0x3FFF. The byte goes to index addr[RAM_AW-1:0], with a default of 8 bits, so contents repeat every 256 bytes. The new byte can be read from the next cycle on.
- R9: No RAM byte changes in two cases: a write while `phi2` is 0, and a write to the unused band, the peripheral window or ROM.
- R10: Synchronous active-high `rst` clears every RAM byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; RAM writes are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address |
| phi2 | input | 1 | Processor phase-2 clock level |
| cpu_we | input | 1 | Processor write strobe, active high |
| wdata | input | 8 | Write data |
| per_rdata | input | 8 | Read data from the peripheral |
| rdata | output | 8 | Read data returned to the processor |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low, qualified by phase 2 |
| ram_oe_n | output | 1 | RAM output enable, active low |
| per_cs1 | output | 1 | Peripheral select, active high |
| per_cs2_n | output | 1 | Peripheral select, active low |
| region | output | 4 | One-hot band indication |

## Verification
Every strobe, the region code and the read data are combinational from `addr` and `phi2`, so they are due in the same cycle as the stimulus. The bench changes its inputs on the falling clock edge and samples one nanosecond later, well before the next rising edge. A RAM write lands on the first rising edge after its inputs are driven. Each readback is therefore driven on the following falling edge, one cycle later, and sampled in that same half period. Reset clearing is checked the same way, on the falling edge after the reset cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] IDLE_BUS = 8'hFF;

    typedef enum logic [3:0] {
        RGN_RAM  = 4'b0001,
        RGN_HOLE = 4'b0010,
        RGN_PER  = 4'b0100,
        RGN_ROM  = 4'b1000
    } region_e;

    typedef struct packed {
        logic    rom_cs_n;
        logic    ram_cs_n;
        logic    ram_oe_n;
        logic    per_cs1;
        logic    per_cs2_n;
        region_e region;
    } strobes_t;

    function automatic logic [DATA_W-1:0] rom_byte(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] vec
    );
        logic [DATA_W-1:0] b;
        if (a == 16'hFFFC)      b = vec[7:0];
        else if (a == 16'hFFFD) b = vec[15:8];
        else                    b = a[7:0] ^ a[15:8];
        return b;
    endfunction

endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
    import mm_pkg::*;
(
    input  logic [2:0] top_bits,
    input  logic       phi2,
    output strobes_t   stb
);
    logic a15, a14, a13;

    always_comb begin
        a15 = top_bits[2];
        a14 = top_bits[1];
        a13 = top_bits[0];
        stb.rom_cs_n  = ~a15;
        stb.ram_cs_n  = ~(~a15 & phi2);
        stb.ram_oe_n  = a14;
        stb.per_cs1   = a13;
        stb.per_cs2_n = ~(~a15 & a14);
        unique casez (top_bits)
            3'b1??:  stb.region = RGN_ROM;
            3'b011:  stb.region = RGN_PER;
            3'b010:  stb.region = RGN_HOLE;
            default: stb.region = RGN_RAM;
        endcase
    end
endmodule

// File: rtl/mm_ram.sv
module mm_ram
    import mm_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mm_rdmux.sv
module mm_rdmux
    import mm_pkg::*;
(
    input  strobes_t          stb,
    input  logic [DATA_W-1:0] rom_q,
    input  logic [DATA_W-1:0] ram_q,
    input  logic [DATA_W-1:0] per_q,
    output logic [DATA_W-1:0] q
);
    logic ram_drives, per_drives, rom_drives;

    always_comb begin
        ram_drives = ~stb.ram_cs_n & ~stb.ram_oe_n;
        per_drives = stb.per_cs1 & ~stb.per_cs2_n;
        rom_drives = ~stb.rom_cs_n;
        if (rom_drives)      q = rom_q;
        else if (per_drives) q = per_q;
        else if (ram_drives) q = ram_q;
        else                 q = IDLE_BUS;
    end
endmodule

// File: rtl/mm_sys_decode.sv
module mm_sys_decode
    import mm_pkg::*;
#(
    parameter int          RAM_AW    = 8,
    parameter logic [15:0] RESET_VEC = 16'h8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        phi2,
    input  logic        cpu_we,
    input  logic [7:0]  wdata,
    input  logic [7:0]  per_rdata,
    output logic [7:0]  rdata,
    output logic        rom_cs_n,
    output logic        ram_cs_n,
    output logic        ram_oe_n,
    output logic        per_cs1,
    output logic        per_cs2_n,
    output logic [3:0]  region
);
    strobes_t          stb;
    logic [DATA_W-1:0] rom_q, ram_q;
    logic              ram_wr;

    mm_addr_decode u_dec (
        .top_bits (addr[15:13]),
        .phi2     (phi2),
        .stb      (stb)
    );

    assign ram_wr = cpu_we & ~stb.ram_cs_n & ~stb.ram_oe_n;

    mm_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ram_wr),
        .idx   (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .rdata (ram_q)
    );

    assign rom_q = rom_byte(addr, RESET_VEC);

    mm_rdmux u_mux (
        .stb   (stb),
        .rom_q (rom_q),
        .ram_q (ram_q),
        .per_q (per_rdata),
        .q     (rdata)
    );

    assign rom_cs_n  = stb.rom_cs_n;
    assign ram_cs_n  = stb.ram_cs_n;
    assign ram_oe_n  = stb.ram_oe_n;
    assign per_cs1   = stb.per_cs1;
    assign per_cs2_n = stb.per_cs2_n;
    assign region    = stb.region;
endmodule

// File: rtl/mm_decode_chk.sv
module mm_decode_chk #(
    parameter logic [15:0] RESET_VEC = 16'h8000
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        phi2,
    input logic [7:0]  rdata,
    input logic        rom_cs_n,
    input logic        ram_cs_n,
    input logic        ram_oe_n,
    input logic        per_cs1,
    input logic        per_cs2_n,
    input logic [3:0]  region
);
    AST_ROM_TOP_HALF: assert property (@(posedge clk) disable iff (rst)
        addr[15] |-> (!rom_cs_n && ram_cs_n && per_cs2_n)); // R1
    AST_ROM_PHASE_FREE: assert property (@(posedge clk) disable iff (rst)
        (addr[15] && $stable(addr) && !$stable(phi2)) |-> $stable(rom_cs_n)); // R1
    AST_RAM_CS_PHASE: assert property (@(posedge clk) disable iff (rst)
        !ram_cs_n |-> (phi2 && !addr[15])); // R2
    AST_RAM_OE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!ram_cs_n && !ram_oe_n) |-> (region == 4'b0001)); // R3
    AST_PER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (per_cs1 && !per_cs2_n) |-> (region == 4'b0100)); // R4
    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(region) == 1); // R5
    AST_HOLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (region == 4'b0010) |-> (rdata == 8'hFF)); // R6
    AST_ROM_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (addr == 16'hFFFD) |-> (rdata == RESET_VEC[15:8])); // R7
endmodule

bind mm_sys_decode mm_decode_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .phi2      (phi2),
    .rdata     (rdata),
    .rom_cs_n  (rom_cs_n),
    .ram_cs_n  (ram_cs_n),
    .ram_oe_n  (ram_oe_n),
    .per_cs1   (per_cs1),
    .per_cs2_n (per_cs2_n),
    .region    (region)
);

// File: tb/tb_mm_sys_decode.sv
`timescale 1ns/1ps
module tb_mm_sys_decode;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        phi2;
    logic        cpu_we;
    logic [7:0]  wdata;
    logic [7:0]  per_rdata;
    logic [7:0]  rdata;
    logic        rom_cs_n, ram_cs_n, ram_oe_n, per_cs1, per_cs2_n;
    logic [3:0]  region;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mm_sys_decode dut (
        .clk(clk), .rst(rst), .addr(addr), .phi2(phi2), .cpu_we(cpu_we),
        .wdata(wdata), .per_rdata(per_rdata), .rdata(rdata),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .per_cs1(per_cs1), .per_cs2_n(per_cs2_n), .region(region)
    );

    // {addr, phi2, rom_cs_n, ram_cs_n, ram_oe_n, per_cs1, per_cs2_n, region}
    localparam int NV = 13;
    localparam logic [25:0] VEC [NV] = '{
        {16'h0000, 1'b1, 5'b10001, 4'b0001},
        {16'h1234, 1'b0, 5'b11001, 4'b0001},
        {16'h3FFF, 1'b1, 5'b10011, 4'b0001},
        {16'h2000, 1'b1, 5'b10011, 4'b0001},
        {16'h4000, 1'b1, 5'b10100, 4'b0010},
        {16'h5FFF, 1'b0, 5'b11100, 4'b0010},
        {16'h6000, 1'b1, 5'b10110, 4'b0100},
        {16'h7FFF, 1'b0, 5'b11110, 4'b0100},
        {16'h8000, 1'b0, 5'b01001, 4'b1000},
        {16'h8000, 1'b1, 5'b01001, 4'b1000},
        {16'hC000, 1'b1, 5'b01101, 4'b1000},
        {16'hE000, 1'b0, 5'b01111, 4'b1000},
        {16'hFFFC, 1'b1, 5'b01111, 4'b1000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic p, input logic we, input logic [7:0] d);
        @(negedge clk);
        addr = a; phi2 = p; cpu_we = we; wdata = d;
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic p, input logic [7:0] d);
        drive(a, p, 1'b1, d);
        @(posedge clk);
        #0.5 cpu_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic p, input logic [7:0] exp);
        drive(a, p, 1'b0, 8'h00);
        check(req, {8'h00, rdata}, {8'h00, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #20000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; phi2 = 1'b0; cpu_we = 1'b0; wdata = '0;
        per_rdata = 8'h5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state of RAM
        rd("R10 reset clears RAM", 16'h0010, 1'b1, 8'h00);

        // R1..R5 vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][25:10], VEC[i][9], 1'b0, 8'h00);
            check("R1 rom_cs_n",  {15'd0, rom_cs_n},  {15'd0, VEC[i][8]});
            check("R2 ram_cs_n",  {15'd0, ram_cs_n},  {15'd0, VEC[i][7]});
            check("R3 ram_oe_n",  {15'd0, ram_oe_n},  {15'd0, VEC[i][6]});
            check("R4 per_cs1",   {15'd0, per_cs1},   {15'd0, VEC[i][5]});
            check("R4 per_cs2_n", {15'd0, per_cs2_n}, {15'd0, VEC[i][4]});
            check("R5 region",    {12'd0, region},    {12'd0, VEC[i][3:0]});
        end

        // R8 write and readback, mirror
        wr(16'h0010, 1'b1, 8'hA5);
        rd("R8 readback", 16'h0010, 1'b1, 8'hA5);
        rd("R8 mirror", 16'h0110, 1'b1, 8'hA5);
        wr(16'h3FFF, 1'b1, 8'h3C);
        rd("R8 top of RAM band", 16'h00FF, 1'b1, 8'h3C);

        // R9 ignored writes
        wr(16'h0020, 1'b0, 8'h11);
        rd("R9 phi2 low write ignored", 16'h0020, 1'b1, 8'h00);
        wr(16'h4020, 1'b1, 8'h22);
        rd("R9 hole write ignored", 16'h0020, 1'b1, 8'h00);
        wr(16'h6020, 1'b1, 8'h33);
        rd("R9 peripheral write ignored", 16'h0020, 1'b1, 8'h00);
        wr(16'h8020, 1'b1, 8'h44);
        rd("R9 ROM write ignored", 16'h0020, 1'b1, 8'h00);

        // R6 read mux
        rd("R6 RAM with phi2 low", 16'h0010, 1'b0, 8'hFF);
        rd("R6 hole", 16'h4010, 1'b1, 8'hFF);
        rd("R6 peripheral", 16'h6003, 1'b1, 8'h5A);
        per_rdata = 8'hC3;
        rd("R6 peripheral mirror", 16'h7F0E, 1'b0, 8'hC3);

        // R7 ROM contents and vector
        rd("R7 ROM byte", 16'h9234, 1'b1, 8'hA6);
        rd("R7 ROM byte phi2 low", 16'hFFFE, 1'b0, 8'h01);
        rd("R7 vector low", 16'hFFFC, 1'b1, 8'h00);
        rd("R7 vector high", 16'hFFFD, 1'b0, 8'h80);

        // R10 reset after writes
        do_reset();
        rd("R10 reset clears written byte", 16'h0010, 1'b1, 8'h00);
        rd("R10 reset clears top byte", 16'h00FF, 1'b1, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule